// File: doc/BRIEF.md
# Iterative Quadratic-Rotation Block Cipher Core

This core encrypts or decrypts one 128-bit block at a time with a 20-round cipher. Its round mixes four 32-bit working words with the quadratic map x(2x+1) mod 2^32, a fixed rotation by five bits, rotations whose amounts come from the data, XOR, and modular addition or subtraction. One round completes per clock.

The host places a block on `blockIn`, selects the direction with `decryptIn` and pulses `startIn`. The core does not expand keys. It reads a 44-word subkey store held outside the block through two combinational read ports. The core drives the word indices on `keyIdxA` and `keyIdxB`, and the store must return the addressed words in the same cycle. Twenty-two clock edges after the start is accepted, `doneOut` pulses for one cycle and `blockOut` carries the result. The result stays on `blockOut` until the next start.

Top module: `qrbc_core`

## Requirements
- R1: After reset, `busyOut` and `doneOut` are 0 and `blockOut` is all zeros.
- R2: Word A is `blockIn[31:0]`, B is `[63:32]`, C is `[95:64]` and D is `[127:96]`, and `blockOut` uses the same mapping. Encryption first adds S[0] to B and S[1] to D, all mod 2^32. For each round i = 1..20 it then forms t = rotl(B*(2B+1), 5) and u = rotl(D*(2D+1), 5). It sets A = rotl(A^t, u) + S[2i] and C = rotl(C^u, t) + S[2i+1], and moves the words so that (A,B,C,D) becomes (B,C,D,A). Finally it adds S[42] to A and S[43] to C.
- R3: Decryption first subtracts S[42] from A and S[43] from C. It then runs rounds i = 20 down to 1. Each round moves the words so that (A,B,C,D) becomes (D,A,B,C), forms t and u from B and D as in encryption, and sets C = rotr(C - S[2i+1], t) ^ u and A = rotr(A - S[2i], u) ^ t. Finally it subtracts S[0] from B and S[1] from D.
- R4: Decrypting the output of an encryption under the same subkeys returns the original block.
- R5: A start is accepted on a clock edge where `startIn` is 1 and `busyOut` is 0. `busyOut` stays 1 from the next cycle until `doneOut` rises. `doneOut` is set by the 22nd edge after acceptance and is high for exactly one cycle, with `busyOut` 0 in that cycle.
- R6: A `startIn` pulse while `busyOut` is 1 does not change the result or its timing.
- R7: The core reads subkeys in a fixed order, with `keyIdxB` always one more than `keyIdxA`. In the first busy cycle `keyIdxA` is 0 when encrypting and 42 when decrypting. In each round cycle it is 2i for the round being computed. In the last busy cycle it is 42 when encrypting and 0 when decrypting.
- R8: Each variable rotation uses only the 5 least significant bits of its amount.
- R9: While the core is idle and no start is given, `blockOut` holds its value.
- R10: The direction is captured when a start is accepted, so later changes on `decryptIn` do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start request, accepted when idle |
| decryptIn | input | 1 | 1 = decrypt, 0 = encrypt; sampled at start |
| blockIn | input | 128 | Input block, word A in bits 31:0 |
| keyIdxA | output | 6 | Index of the subkey wanted on port A |
| keyIdxB | output | 6 | Index of the subkey wanted on port B |
| keyWordA | input | 32 | Subkey word addressed by keyIdxA, same cycle |
| keyWordB | input | 32 | Subkey word addressed by keyIdxB, same cycle |
| busyOut | output | 1 | Operation in progress |
| doneOut | output | 1 | One-cycle strobe, result valid |
| blockOut | output | 128 | Result block, same word mapping |

## Verification
An all-zero block with all-zero subkeys tests the quadratic map where every product and rotation amount is zero. An all-ones block tests the wrap of mod 2^32 addition and maximal rotation amounts. Many seeded random blocks under several random subkey arrays are each encrypted and then decrypted. These runs separate a wrong round equation from a wrong word order, since each direction is compared with its own model and the round trip must return the input. One run gets a second start with the opposite direction and an inverted block in mid-operation, which shows whether start masking and direction capture work.

// File: rtl/qrbc_pkg.sv
package qrbc_pkg;

  // Control phases of one cipher operation.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_RUN  = 2'd2,
    PH_POST = 2'd3
  } phase_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;       // capture host block
    logic preWhite;   // first whitening step
    logic doRound;    // one round this cycle
    logic postWhite;  // last whitening step
    logic dirDec;     // 1 = decryption
  } dpCtrl_t;

endpackage

// File: rtl/qrbc_quad.sv
// y = rotl(x*(2x+1) mod 2^W, log2(W))
module qrbc_quad #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] xIn,
  output logic [WORD_W-1:0] yOut
);
  localparam int LG_W = $clog2(WORD_W);

  logic [WORD_W-1:0] prod;

  always_comb begin
    prod = xIn * {xIn[WORD_W-2:0], 1'b1};
    yOut = {prod[WORD_W-LG_W-1:0], prod[WORD_W-1:WORD_W-LG_W]};
  end
endmodule

// File: rtl/qrbc_ctrl.sv
module qrbc_ctrl
  import qrbc_pkg::*;
#(
  parameter int ROUNDS = 20
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  startIn,
  input  logic                                  decryptIn,
  output dpCtrl_t                               dpCtrl,
  output logic [$clog2(2*ROUNDS+4)-1:0]         keyIdxA,
  output logic [$clog2(2*ROUNDS+4)-1:0]         keyIdxB,
  output logic                                  busyOut,
  output logic                                  doneOut
);
  localparam int KEY_WORDS = 2 * ROUNDS + 4;
  localparam int IDX_W     = $clog2(KEY_WORDS);
  localparam int RND_W     = $clog2(ROUNDS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_WORDS - 2);

  phase_t           phase;
  logic [RND_W-1:0] rnd;
  logic             decMode;
  logic             lastRnd;

  assign lastRnd = decMode ? (rnd == RND_W'(1)) : (rnd == RND_W'(ROUNDS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      rnd     <= '0;
      decMode <= 1'b0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      unique case (phase)
        PH_IDLE: if (startIn) begin
          phase   <= PH_PRE;
          decMode <= decryptIn;
          rnd     <= decryptIn ? RND_W'(ROUNDS) : RND_W'(1);
        end
        PH_PRE:  phase <= PH_RUN;
        PH_RUN: begin
          if (lastRnd) phase <= PH_POST;
          else         rnd   <= decMode ? rnd - 1'b1 : rnd + 1'b1;
        end
        PH_POST: begin
          phase   <= PH_IDLE;
          doneOut <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtrl.load      = (phase == PH_IDLE) && startIn;
    dpCtrl.preWhite  = (phase == PH_PRE);
    dpCtrl.doRound   = (phase == PH_RUN);
    dpCtrl.postWhite = (phase == PH_POST);
    dpCtrl.dirDec    = decMode;
    unique case (phase)
      PH_PRE:  keyIdxA = decMode ? LAST_IDX : '0;
      PH_RUN:  keyIdxA = IDX_W'({rnd, 1'b0});
      PH_POST: keyIdxA = decMode ? '0 : LAST_IDX;
      default: keyIdxA = '0;
    endcase
    keyIdxB = keyIdxA + 1'b1;
  end

  assign busyOut = (phase != PH_IDLE);
endmodule

// File: rtl/qrbc_datapath.sv
module qrbc_datapath
  import qrbc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             dpCtrl,
  input  logic [4*WORD_W-1:0] blockIn,
  input  logic [WORD_W-1:0]   keyWordA,
  input  logic [WORD_W-1:0]   keyWordB,
  output logic [4*WORD_W-1:0] blockOut
);
  localparam int LG_W = $clog2(WORD_W);

  function automatic logic [WORD_W-1:0] rotL(input logic [WORD_W-1:0] x,
                                             input logic [LG_W-1:0] n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << n;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  function automatic logic [WORD_W-1:0] rotR(input logic [WORD_W-1:0] x,
                                             input logic [LG_W-1:0] n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} >> n;
    return dbl[WORD_W-1:0];
  endfunction

  logic [WORD_W-1:0] wA, wB, wC, wD;
  logic [WORD_W-1:0] quadIn  [2];
  logic [WORD_W-1:0] quadOut [2];
  logic [WORD_W-1:0] tVal, uVal;
  logic [WORD_W-1:0] encA, encC, decA, decC;

  // Decryption's word move puts old A and C into the B and D slots.
  assign quadIn[0] = dpCtrl.dirDec ? wA : wB;
  assign quadIn[1] = dpCtrl.dirDec ? wC : wD;

  for (genvar g = 0; g < 2; g++) begin : g_quad
    qrbc_quad #(.WORD_W(WORD_W)) u_quad (.xIn(quadIn[g]), .yOut(quadOut[g]));
  end

  assign tVal = quadOut[0];
  assign uVal = quadOut[1];

  always_comb begin
    encA = rotL(wA ^ tVal, uVal[LG_W-1:0]) + keyWordA;
    encC = rotL(wC ^ uVal, tVal[LG_W-1:0]) + keyWordB;
    decA = rotR(wD - keyWordA, uVal[LG_W-1:0]) ^ tVal;
    decC = rotR(wB - keyWordB, tVal[LG_W-1:0]) ^ uVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {wD, wC, wB, wA} <= '0;
    end else if (dpCtrl.load) begin
      {wD, wC, wB, wA} <= blockIn;
    end else if (dpCtrl.preWhite) begin
      if (dpCtrl.dirDec) begin
        wA <= wA - keyWordA;
        wC <= wC - keyWordB;
      end else begin
        wB <= wB + keyWordA;
        wD <= wD + keyWordB;
      end
    end else if (dpCtrl.doRound) begin
      if (dpCtrl.dirDec) {wA, wB, wC, wD} <= {decA, wA, decC, wC};
      else               {wA, wB, wC, wD} <= {wB, encC, wD, encA};
    end else if (dpCtrl.postWhite) begin
      if (dpCtrl.dirDec) begin
        wB <= wB - keyWordA;
        wD <= wD - keyWordB;
      end else begin
        wA <= wA + keyWordA;
        wC <= wC + keyWordB;
      end
    end
  end

  assign blockOut = {wD, wC, wB, wA};
endmodule

// File: rtl/qrbc_core.sv
module qrbc_core
  import qrbc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ROUNDS = 20
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               startIn,
  input  logic                               decryptIn,
  input  logic [4*WORD_W-1:0]                blockIn,
  output logic [$clog2(2*ROUNDS+4)-1:0]      keyIdxA,
  output logic [$clog2(2*ROUNDS+4)-1:0]      keyIdxB,
  input  logic [WORD_W-1:0]                  keyWordA,
  input  logic [WORD_W-1:0]                  keyWordB,
  output logic                               busyOut,
  output logic                               doneOut,
  output logic [4*WORD_W-1:0]                blockOut
);
  dpCtrl_t dpCtrl;

  qrbc_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .decryptIn(decryptIn),
    .dpCtrl(dpCtrl), .keyIdxA(keyIdxA), .keyIdxB(keyIdxB),
    .busyOut(busyOut), .doneOut(doneOut)
  );

  qrbc_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .blockIn(blockIn),
    .keyWordA(keyWordA), .keyWordB(keyWordB), .blockOut(blockOut)
  );
endmodule

// File: rtl/qrbc_checker.sv
module qrbc_checker #(
  parameter int WORD_W = 32,
  parameter int ROUNDS = 20
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          startIn,
  input logic                          busyOut,
  input logic                          doneOut,
  input logic [$clog2(2*ROUNDS+4)-1:0] keyIdxA,
  input logic [4*WORD_W-1:0]           blockOut
);
  localparam int KEY_WORDS = 2 * ROUNDS + 4;
  localparam int LAT       = ROUNDS + 2;
  localparam int CNT_W     = $clog2(LAT + 1) + 1;

  logic [CNT_W-1:0] latCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     latCnt <= '0;
    else if (startIn && !busyOut)  latCnt <= '0;
    else if (busyOut)              latCnt <= latCnt + 1'b1;
  end

  // R5: done lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
  // R5: done arrives exactly LAT edges after acceptance
  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (latCnt == CNT_W'(LAT)));
  // R5: accepted start makes the core busy
  a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyOut) |=> busyOut);
  // R5: done ends a busy period
  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (!busyOut && $past(busyOut)));
  // R6: a start while busy does not cut the operation short
  a_r6_start_masked: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && startIn) |=> (busyOut || doneOut));
  // R7: subkey index stays inside the store
  a_r7_index_range: assert property (@(posedge clk) disable iff (!rstN)
    busyOut |-> (int'(keyIdxA) < KEY_WORDS - 1));
  // R9: idle output holds
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOut && !startIn) |=> $stable(blockOut));
endmodule

bind qrbc_core qrbc_checker #(.WORD_W(WORD_W), .ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .busyOut(busyOut),
  .doneOut(doneOut), .keyIdxA(keyIdxA), .blockOut(blockOut)
);

// File: tb/qrbc_core_bench.sv
`timescale 1ns/1ps
module qrbc_core_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic         decryptIn = 1'b0;
  logic [127:0] blockIn = '0;
  logic [5:0]   keyIdxA, keyIdxB;
  logic [31:0]  keyWordA, keyWordB;
  logic         busyOut, doneOut;
  logic [127:0] blockOut;

  logic [31:0] keyMem [44];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign keyWordA = (keyIdxA < 6'd44) ? keyMem[keyIdxA] : 32'h0;
  assign keyWordB = (keyIdxB < 6'd44) ? keyMem[keyIdxB] : 32'h0;

  qrbc_core u_qrbc_core (
    .clk(clk), .rstN(rstN), .startIn(startIn), .decryptIn(decryptIn),
    .blockIn(blockIn), .keyIdxA(keyIdxA), .keyIdxB(keyIdxB),
    .keyWordA(keyWordA), .keyWordB(keyWordB), .busyOut(busyOut),
    .doneOut(doneOut), .blockOut(blockOut)
  );

  // ---------------- model ----------------
  function automatic logic [31:0] mRotl(input logic [31:0] x, input logic [31:0] n);
    int s = int'(n[4:0]);   // R8: only 5 LSBs
    return (s == 0) ? x : ((x << s) | (x >> (32 - s)));
  endfunction
  function automatic logic [31:0] mRotr(input logic [31:0] x, input logic [31:0] n);
    int s = int'(n[4:0]);
    return (s == 0) ? x : ((x >> s) | (x << (32 - s)));
  endfunction
  function automatic logic [31:0] mQuad(input logic [31:0] x);
    logic [31:0] p = x * (2 * x + 32'd1);
    return mRotl(p, 32'd5);
  endfunction

  function automatic logic [127:0] modelEnc(input logic [127:0] blk);
    logic [31:0] a, b, c, d, t, u, tmp;
    {d, c, b, a} = blk;
    b = b + keyMem[0];
    d = d + keyMem[1];
    for (int i = 1; i <= 20; i++) begin
      t = mQuad(b);
      u = mQuad(d);
      a = mRotl(a ^ t, u) + keyMem[2*i];
      c = mRotl(c ^ u, t) + keyMem[2*i+1];
      tmp = a; a = b; b = c; c = d; d = tmp;
    end
    a = a + keyMem[42];
    c = c + keyMem[43];
    return {d, c, b, a};
  endfunction

  function automatic logic [127:0] modelDec(input logic [127:0] blk);
    logic [31:0] a, b, c, d, t, u, tmp;
    {d, c, b, a} = blk;
    c = c - keyMem[43];
    a = a - keyMem[42];
    for (int i = 20; i >= 1; i--) begin
      tmp = d; d = c; c = b; b = a; a = tmp;
      t = mQuad(b);
      u = mQuad(d);
      c = mRotr(c - keyMem[2*i+1], t) ^ u;
      a = mRotr(a - keyMem[2*i], u) ^ t;
    end
    b = b - keyMem[0];
    d = d - keyMem[1];
    return {d, c, b, a};
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fillKeys(input bit zero);
    for (int k = 0; k < 44; k++) keyMem[k] = zero ? 32'h0 : $urandom;
  endtask

  // Runs one operation; injectAt >= 0 raises a second start at that busy cycle.
  task automatic runOp(input logic [127:0] blk, input bit dec, input int injectAt,
                       output logic [127:0] res, output int lat,
                       output logic [23:0] idxSeq, output bit busyLost,
                       output bit pairBad);
    int n;
    busyLost = 0;
    pairBad  = 0;
    idxSeq   = '0;
    @(negedge clk);
    blockIn = blk; decryptIn = dec; startIn = 1'b1;
    @(posedge clk);
    n = -1;
    while (1) begin
      @(negedge clk);
      n++;
      startIn = 1'b0;
      if (doneOut || n > 60) break;
      if (!busyOut) busyLost = 1;
      if (keyIdxB != keyIdxA + 6'd1) pairBad = 1;
      if (n == 0)  idxSeq[23:18] = keyIdxA;
      if (n == 1)  idxSeq[17:12] = keyIdxA;
      if (n == 20) idxSeq[11:6]  = keyIdxA;
      if (n == 21) idxSeq[5:0]   = keyIdxA;
      if (n == injectAt) begin
        startIn = 1'b1; blockIn = ~blk; decryptIn = ~dec;
      end
    end
    res = blockOut;
    lat = n;
    decryptIn = dec;
  endtask

  task automatic opAndCheck(input logic [127:0] blk, input bit dec, input int injectAt,
                            output logic [127:0] res);
    int lat;
    logic [23:0] seq;
    bit lost, pairBad;
    logic [127:0] exp;
    exp = dec ? modelDec(blk) : modelEnc(blk);
    runOp(blk, dec, injectAt, res, lat, seq, lost, pairBad);
    check(dec ? "R3 decrypt result" : "R2 encrypt result", res, exp);
    check("R5 latency", 128'(lat), 128'd22);
    check("R5 busy held", 128'(lost), 128'd0);
    check("R7 index order", 128'(seq),
          dec ? 128'({6'd42, 6'd40, 6'd2, 6'd0}) : 128'({6'd0, 6'd2, 6'd40, 6'd42}));
    check("R7 index pair", 128'(pairBad), 128'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [127:0] pt, ct, rt, held;
    void'($urandom(32'h5eed_c0de));
    fillKeys(1);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", 128'(busyOut), 128'd0);
    check("R1 done", 128'(doneOut), 128'd0);
    check("R1 block", blockOut, 128'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R4 directed: all zero block with zero subkeys
    opAndCheck(128'h0, 1'b0, -1, ct);
    opAndCheck(ct, 1'b1, -1, rt);
    check("R4 zero round trip", rt, 128'h0);

    // R8/R4 directed: all ones block, random keys (wrapping sums, large amounts)
    fillKeys(0);
    pt = '1;
    opAndCheck(pt, 1'b0, -1, ct);
    opAndCheck(ct, 1'b1, -1, rt);
    check("R4 ones round trip", rt, pt);

    // R9: idle hold with changing inputs and no start
    held = blockOut;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      blockIn = {$urandom, $urandom, $urandom, $urandom};
      decryptIn = ~decryptIn;
    end
    @(negedge clk);
    check("R9 idle hold", blockOut, held);

    // R6/R10: second start with opposite mode mid-operation
    pt = {$urandom, $urandom, $urandom, $urandom};
    opAndCheck(pt, 1'b0, 5, ct);
    check("R6 R10 masked start", ct, modelEnc(pt));
    opAndCheck(ct, 1'b1, 9, rt);
    check("R10 masked decrypt", rt, pt);

    // R2/R3/R4 random
    for (int it = 0; it < 30; it++) begin
      if (it % 10 == 0) fillKeys(0);
      pt = {$urandom, $urandom, $urandom, $urandom};
      opAndCheck(pt, 1'b0, -1, ct);
      opAndCheck(ct, 1'b1, -1, rt);
      check("R4 random round trip", rt, pt);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule